// File: doc/BRIEF.md
# Simultaneous Perturbation Weight Trainer

This block is the digital controller for training a small stack of neural network layers by simultaneous perturbation. No gradient, derivative or backward pass is involved. For every training pattern it draws a fresh random sign for every weight and latches the target vector. It then collects the output vector of a forward pass made with the stored weights. Next it asks the weight store to offset every weight at once by its sign times the perturbation size, and collects a second forward pass. Finally it asks the weight store to remove the offset and streams one signed update per weight.

Each update is the single scalar error difference, scaled by the learning rate and by the reciprocal of the perturbation size, multiplied by minus the weight's own sign. Both the sign and the size of the error change therefore reach every weight. The matrix-vector product and the activation function sit outside, in the weight store and its datapath. Every pattern takes exactly two forward evaluations, whatever the number of layers.

Top module: `sp_trainer`

## Requirements
- R1: While `rst_n` is low (synchronous reset), `busy_o`, `pert_req_o`, `restore_req_o` and `upd_valid_o` are 0, and the sign generator state is loaded from `seed_i`. A zero seed is replaced by 1.
- R2: Signs come from a 32-bit Fibonacci shift register. Each step shifts left and inserts `s[31]^s[21]^s[1]^s[0]` at bit 0. Weight k (k = 0..NW-1) takes the bit inserted at step k+1 of the draw. Bit 1 means sign +1 and bit 0 means sign -1. Each accepted start advances the register by NW steps, and `sign_o` holds the drawn vector from the cycle after the start until the next accepted start.
- R3: `pert_req_o` is high for exactly one cycle, immediately after the first forward result is accepted, with the whole sign vector presented at once.
- R4: The first `fwd_valid_i` after a start is taken as the unperturbed result. The first `fwd_valid_i` seen after the cycle of `pert_req_o` is taken as the perturbed result. `fwd_valid_i` in any other state, including the perturb cycle, is ignored.
- R5: Each error is the sum over outputs of (target - output)^2, with vector elements in signed Q8.8 and element k at bits [16k+15:16k]. The sum is halved and returned to Q8.8 with a floor shift, then clamped to 32767.
- R6: The common scale is ((dE*eta)>>>8 * inv_pert)>>>8, where dE = E_second - E_first and eta and inv_pert are signed Q8.8 sampled in the restore cycle. The scale saturates to the range [-32767, 32767] instead of wrapping.
- R7: Updates stream one per cycle with indices 0..NW-1 in order: layer by layer, rows in order, columns within a row. Update k equals -scale when sign k is +1 and +scale when it is -1.
- R8: `restore_req_o` is high for exactly one cycle after the perturbed result is accepted, and the first update follows in the next cycle.
- R9: `busy_o` is high from the cycle after an accepted start until the last update has been streamed. A start while busy is refused, with no effect on the signs, the register state or the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_i | input | 32 | Sign generator seed, loaded during reset |
| start_i | input | 1 | Start of a training pattern |
| tgt_i | input | NOUT*16 | Target vector, latched with an accepted start |
| eta_i | input | 16 | Learning rate, signed Q8.8 |
| inv_pert_i | input | 16 | Reciprocal of the perturbation size, signed Q8.8 |
| fwd_valid_i | input | 1 | Forward result present |
| fwd_i | input | NOUT*16 | Forward result vector |
| busy_o | output | 1 | Pattern in progress |
| pert_req_o | output | 1 | Apply the signed perturbation to all weights |
| restore_req_o | output | 1 | Remove the perturbation |
| sign_o | output | NW | Sign vector, bit 1 = +1 |
| upd_valid_o | output | 1 | Update present |
| upd_idx_o | output | IDXW | Weight index of the update |
| upd_val_o | output | 16 | Signed Q8.8 weight update |

## Verification
The bench builds the block with two layers of 2x3 weights, which gives twelve signs per pattern, and a three-element output vector. That is small enough to compare every sign and every streamed update against an arithmetic model on every pattern. Over several consecutive draws, the run covers both error differences of zero and of either sign, scale saturation in both directions, error clamping from a full-range difference, a refused start in the middle of a stream, and a zero seed through a second reset.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL0,
        ST_PERT,
        ST_EVAL1,
        ST_REST,
        ST_STREAM
    } sp_state_e;

    // one step of the 32-bit maximal-length sign register
    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction
endpackage

// File: rtl/sp_sign_gen.sv
module sp_sign_gen #(
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   seed_i,
    input  logic          draw_i,
    output logic [NW-1:0] signs_o
);
    import sp_pkg::*;

    logic [31:0] lfsr_d, lfsr_q;
    logic [31:0] walk;

    always_comb begin
        walk = lfsr_q;
        signs_o = '0;
        for (int k = 0; k < NW; k++) begin
            walk = lfsr_next(walk);
            signs_o[k] = walk[0];
        end
        lfsr_d = draw_i ? walk : lfsr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= (seed_i == 32'd0) ? 32'd1 : seed_i;
        else        lfsr_q <= lfsr_d;
    end

    // R2: the register never falls into the all-zero lock-up state
    a_r2_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 32'd0);
endmodule

// File: rtl/sp_err.sv
module sp_err #(
    parameter int NOUT = 3,
    parameter int QW   = 16,
    parameter int FRAC = 8
) (
    input  logic [NOUT*QW-1:0] tgt_i,
    input  logic [NOUT*QW-1:0] fwd_i,
    output logic [QW-1:0]      err_o
);
    localparam logic signed [47:0] LIM = 48'((64'd1 << (QW - 1)) - 64'd1);

    logic signed [47:0] diff;
    logic signed [47:0] acc;
    logic signed [47:0] half;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NOUT; k++) begin
            diff = 48'(signed'(tgt_i[k*QW +: QW])) - 48'(signed'(fwd_i[k*QW +: QW]));
            acc  = acc + diff * diff;
        end
        // squares carry 2*FRAC fraction bits: halve and return to FRAC
        half  = acc >>> (FRAC + 1);
        err_o = (half > LIM) ? QW'(LIM) : QW'(half);
    end
endmodule

// File: rtl/sp_scale.sv
module sp_scale #(
    parameter int QW   = 16,
    parameter int FRAC = 8
) (
    input  logic [QW-1:0] e_first_i,
    input  logic [QW-1:0] e_second_i,
    input  logic [QW-1:0] eta_i,
    input  logic [QW-1:0] inv_pert_i,
    output logic [QW-1:0] scale_o
);
    localparam logic signed [47:0] LIM = 48'((64'd1 << (QW - 1)) - 64'd1);

    logic signed [47:0] de, p_eta, p_full;

    always_comb begin
        de     = signed'(48'(e_second_i)) - signed'(48'(e_first_i));
        p_eta  = (de * 48'(signed'(eta_i))) >>> FRAC;
        p_full = (p_eta * 48'(signed'(inv_pert_i))) >>> FRAC;
        if (p_full > LIM)       scale_o = QW'(LIM);
        else if (p_full < -LIM) scale_o = QW'(-LIM);
        else                    scale_o = QW'(p_full);
    end
endmodule

// File: rtl/sp_trainer.sv
module sp_trainer #(
    parameter int NLAYER = 2,
    parameter int NROW   = 2,
    parameter int NCOL   = 3,
    parameter int NOUT   = 3,
    parameter int QW     = 16,
    parameter int FRAC   = 8,
    localparam int NW    = NLAYER * NROW * NCOL,
    localparam int IDXW  = (NW > 1) ? $clog2(NW) : 1,
    localparam int VW    = NOUT * QW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     seed_i,
    input  logic            start_i,
    input  logic [VW-1:0]   tgt_i,
    input  logic [QW-1:0]   eta_i,
    input  logic [QW-1:0]   inv_pert_i,
    input  logic            fwd_valid_i,
    input  logic [VW-1:0]   fwd_i,
    output logic            busy_o,
    output logic            pert_req_o,
    output logic            restore_req_o,
    output logic [NW-1:0]   sign_o,
    output logic            upd_valid_o,
    output logic [IDXW-1:0] upd_idx_o,
    output logic [QW-1:0]   upd_val_o
);
    import sp_pkg::*;

    typedef struct packed {
        sp_state_e       st;
        logic [VW-1:0]   tgt;
        logic [NW-1:0]   sign;
        logic [QW-1:0]   e1;
        logic [QW-1:0]   e2;
        logic [QW-1:0]   scale;
        logic [IDXW-1:0] idx;
    } trn_state_t;

    trn_state_t s_d, s_q;
    logic            draw;
    logic [NW-1:0]   drawn;
    logic [QW-1:0]   err_now, scale_now;

    sp_sign_gen #(.NW(NW)) u_sign (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_i),
        .draw_i  (draw),
        .signs_o (drawn)
    );

    sp_err #(.NOUT(NOUT), .QW(QW), .FRAC(FRAC)) u_err (
        .tgt_i (s_q.tgt),
        .fwd_i (fwd_i),
        .err_o (err_now)
    );

    sp_scale #(.QW(QW), .FRAC(FRAC)) u_scale (
        .e_first_i  (s_q.e1),
        .e_second_i (s_q.e2),
        .eta_i      (eta_i),
        .inv_pert_i (inv_pert_i),
        .scale_o    (scale_now)
    );

    always_comb begin
        s_d  = s_q;
        draw = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    draw     = 1'b1;
                    s_d.sign = drawn;
                    s_d.tgt  = tgt_i;
                    s_d.idx  = '0;
                    s_d.st   = ST_EVAL0;
                end
            end
            ST_EVAL0: begin
                if (fwd_valid_i) begin
                    s_d.e1 = err_now;
                    s_d.st = ST_PERT;
                end
            end
            ST_PERT: s_d.st = ST_EVAL1;
            ST_EVAL1: begin
                if (fwd_valid_i) begin
                    s_d.e2 = err_now;
                    s_d.st = ST_REST;
                end
            end
            ST_REST: begin
                s_d.scale = scale_now;
                s_d.st    = ST_STREAM;
            end
            ST_STREAM: begin
                if (s_q.idx == IDXW'(NW - 1)) s_d.st = ST_IDLE;
                else                          s_d.idx = s_q.idx + 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o        = (s_q.st != ST_IDLE);
    assign pert_req_o    = (s_q.st == ST_PERT);
    assign restore_req_o = (s_q.st == ST_REST);
    assign sign_o        = s_q.sign;
    assign upd_valid_o   = (s_q.st == ST_STREAM);
    assign upd_idx_o     = s_q.idx;
    assign upd_val_o     = s_q.sign[s_q.idx] ? QW'(-signed'(s_q.scale)) : s_q.scale;

    // R3: the perturbation request is a single-cycle pulse
    a_r3_pert_single: assert property (@(posedge clk) disable iff (!rst_n)
        pert_req_o |=> !pert_req_o);

    // R8: the restore request comes right before the first update
    a_r8_restore_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_valid_o) |-> $past(restore_req_o));

    // R6: saturation is symmetric, the most negative code never appears
    a_r6_sym_sat: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> (upd_val_o != {1'b1, {(QW-1){1'b0}}}));

    // R7: consecutive updates carry consecutive indices
    a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && $past(upd_valid_o)) |-> (upd_idx_o == IDXW'($past(upd_idx_o) + 1'b1)));

    // R9: a start while busy leaves the signs untouched
    a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(sign_o));
endmodule

// File: tb/tb_sp_trainer.sv
`timescale 1ns/1ps
module tb_sp_trainer;
    localparam int NW   = 12;
    localparam int NOUT = 3;
    localparam int VW   = NOUT * 16;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     seed = 32'hACE1_2468;
    logic            start = 1'b0;
    logic [VW-1:0]   tgt = '0;
    logic [15:0]     eta = 16'h0100;
    logic [15:0]     invp = 16'h0100;
    logic            fv = 1'b0;
    logic [VW-1:0]   fwd = '0;
    logic            busy, pert, rest, uv;
    logic [NW-1:0]   sgn;
    logic [IDXW-1:0] uidx;
    logic [15:0]     uval;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [31:0] m_lfsr;

    always #2 clk = ~clk;

    sp_trainer dut (
        .clk(clk), .rst_n(rst_n), .seed_i(seed), .start_i(start), .tgt_i(tgt),
        .eta_i(eta), .inv_pert_i(invp), .fwd_valid_i(fv), .fwd_i(fwd),
        .busy_o(busy), .pert_req_o(pert), .restore_req_o(rest), .sign_o(sgn),
        .upd_valid_o(uv), .upd_idx_o(uidx), .upd_val_o(uval)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint m_err(input logic [VW-1:0] t, input logic [VW-1:0] o);
        longint acc = 0;
        for (int k = 0; k < NOUT; k++) begin
            longint d = longint'($signed(t[k*16 +: 16])) - longint'($signed(o[k*16 +: 16]));
            acc += d * d;
        end
        acc = acc >>> 9;
        if (acc > 32767) acc = 32767;
        return acc;
    endfunction

    function automatic longint m_scale(input longint e1, input longint e2,
                                       input logic [15:0] et, input logic [15:0] iv);
        longint p = ((e2 - e1) * longint'($signed(et))) >>> 8;
        p = (p * longint'($signed(iv))) >>> 8;
        if (p > 32767) p = 32767;
        if (p < -32767) p = -32767;
        return p;
    endfunction

    task automatic do_reset(input logic [31:0] sd);
        rst_n = 1'b0;
        seed = sd;
        m_lfsr = (sd == 0) ? 32'd1 : sd;
        repeat (3) @(negedge clk);
        chk(busy == 0 && pert == 0 && rest == 0 && uv == 0, "R1 reset outputs",
            {busy, pert, rest, uv}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R1 idle after reset", busy, 0);
    endtask

    task automatic pattern(input logic [VW-1:0] t, input logic [VW-1:0] o0,
                           input logic [VW-1:0] o1, input logic [15:0] et,
                           input logic [15:0] iv, input bit refuse);
        logic [NW-1:0] es;
        longint sc, ev;
        for (int k = 0; k < NW; k++) begin
            m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
            es[k] = m_lfsr[0];
        end
        sc = m_scale(m_err(t, o0), m_err(t, o1), et, iv);
        eta = et;
        invp = iv;
        tgt = t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1, "R9 busy after start", busy, 1);
        chk(sgn == es, "R2 drawn signs", sgn, es);
        fv = 1'b1;
        fwd = o0;
        @(negedge clk);
        fv = 1'b0;
        chk(pert == 1 && rest == 0, "R3 perturb after first eval", pert, 1);
        // R4: offered during the perturb cycle (ignored) and accepted in the next
        fv = 1'b1;
        fwd = o1;
        @(negedge clk);
        chk(pert == 0, "R3 single perturb pulse", pert, 0);
        @(negedge clk);
        fv = 1'b0;
        chk(rest == 1 && uv == 0, "R8 restore before update", rest, 1);
        @(negedge clk);
        for (int k = 0; k < NW; k++) begin
            ev = es[k] ? -sc : sc;
            chk(uv == 1 && uidx == IDXW'(k), "R7 update index", uidx, k);
            chk($signed(uval) == ev, "R6 R7 update value", $signed(uval), ev);
            if (refuse && k == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        chk(busy == 0 && uv == 0, "R9 idle after stream", busy, 0);
    endtask

    function automatic logic [VW-1:0] vec(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c);
        return {c, b, a};
    endfunction

    initial begin
        do_reset(32'hACE1_2468);
        // R4: a forward result while idle has no effect
        fv = 1'b1;
        @(negedge clk);
        fv = 1'b0;
        chk(busy == 0 && pert == 0, "R4 idle result ignored", busy, 0);
        // R5: equal outputs, zero error change
        pattern(vec(16'h0100, 16'hFF00, 16'h0080), vec(16'h0100, 16'hFF00, 16'h0080),
                vec(16'h0100, 16'hFF00, 16'h0080), 16'h0100, 16'h0100, 0);
        // R5: perturbed output closer to target, negative dE
        pattern(vec(16'h0200, 16'h0000, 16'hFE00), vec(16'h0000, 16'h0300, 16'h0000),
                vec(16'h0180, 16'h0080, 16'hFF00), 16'h0100, 16'h0100, 0);
        // R6: perturbed output further away, fractional eta, refused start (R9)
        pattern(vec(16'h0040, 16'hFFC0, 16'h0100), vec(16'h0050, 16'hFFB0, 16'h0110),
                vec(16'h0200, 16'h0100, 16'hFE00), 16'h0080, 16'h0400, 1);
        // R6: positive saturation
        pattern('0, vec(16'h0100, 16'h0100, 16'h0100), vec(16'h0200, 16'h0200, 16'h0200),
                16'h7FFF, 16'h7FFF, 0);
        // R6: negative saturation
        pattern('0, vec(16'h0200, 16'h0200, 16'h0200), vec(16'h0100, 16'h0100, 16'h0100),
                16'h7FFF, 16'h7FFF, 0);
        // R5: full-range difference clamps the error
        pattern(vec(16'h7FFF, 16'h7FFF, 16'h7FFF), vec(16'h8000, 16'h8000, 16'h8000),
                vec(16'h7FFF, 16'h7FFF, 16'h7FFF), 16'h0100, 16'h0100, 0);
        // R6: negative learning rate
        pattern(vec(16'h0100, 16'h0000, 16'h0000), vec(16'h0000, 16'h0000, 16'h0000),
                vec(16'h0080, 16'h0000, 16'h0040), 16'hFF00, 16'h0200, 0);
        // R1: zero seed becomes one
        do_reset(32'd0);
        pattern(vec(16'h0300, 16'h0000, 16'h0000), vec(16'h0000, 16'h0000, 16'h0000),
                vec(16'h0100, 16'h0000, 16'h0000), 16'h0100, 16'h0100, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule